// File: doc/BRIEF.md
# Charge-Pump Supply Undervoltage Supervisor

This block watches a digital flag from an external comparator that rises while the charge-pump supply sits below its threshold. The flag must stay high for a configurable number of consecutive clock samples before the block treats it as a real undervoltage. Once the fault is confirmed, the block turns on the gate-driver pull-downs, drives the active-low fault pin, and sets a global fault status bit and a sticky undervoltage status bit.

Two recovery policies are available. In latched mode the block also switches the charge pump off, and everything holds until a clear-fault pulse arrives after the supply has recovered. In automatic mode the fault pin and the global bit drop by themselves as soon as the flag is sampled low. Only the sticky bit then waits for a clear-fault pulse. The block passes a threshold-level code through to the comparator. A hardware-variant strap overrides the configuration: it forces automatic recovery and a fixed level code.

Top module: `cp_uv_supervisor`

## Requirements
- R1: A fault is confirmed at the clock edge that samples `uv_below` high for the DEG-th consecutive time. An excursion of DEG-1 samples or fewer confirms nothing.
- R2: On the edge that confirms a fault, `pulldown_en` becomes 1, `flt_n` becomes 0, `flt_status` becomes 1 and `uv_sticky` becomes 1.
- R3: While `hw_strap` is 0, `lvl_out` equals `lvl_cfg` in the same cycle.
- R4: The effective mode is latched when `mode_latch` is 1 and `hw_strap` is 0. Otherwise it is automatic recovery.
- R5: In latched mode `cp_en` is 0 while the fault is active. The fault, the pull-downs and the disabled charge pump persist after `uv_below` falls, until `clr_fault` is sampled high together with `uv_below` low. That edge clears `flt_status` and `uv_sticky` together.
- R6: In automatic mode, the edge that samples `uv_below` low clears `flt_status` and `pulldown_en` and raises `flt_n`. `cp_en` stays 1 throughout.
- R7: In automatic mode `uv_sticky` stays 1 after the fault clears. It drops only at an edge that samples `clr_fault` high with `uv_below` low.
- R8: While `hw_strap` is 1, `lvl_out` equals HW_LVL (default 2'b01), and the block recovers automatically even when `mode_latch` is 1.
- R9: A `clr_fault` pulse sampled while `uv_below` is high changes neither `flt_status` nor `uv_sticky`.
- R10: After reset, `flt_status`, `uv_sticky` and `pulldown_en` are 0, while `flt_n` and `cp_en` are 1.
- R11: An edge that samples `uv_below` low restarts the deglitch count. A new excursion then needs DEG fresh consecutive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_below | input | 1 | Comparator flag, 1 = supply below threshold |
| mode_latch | input | 1 | 1 = latched recovery, 0 = automatic |
| lvl_cfg | input | LVL_W | Configured threshold level code |
| clr_fault | input | 1 | Clear-fault pulse |
| hw_strap | input | 1 | Hardware-variant strap |
| lvl_out | output | LVL_W | Level code forwarded to the comparator |
| pulldown_en | output | 1 | Gate-driver pull-down enable |
| flt_n | output | 1 | Active-low fault pin |
| flt_status | output | 1 | Global fault status bit |
| uv_sticky | output | 1 | Sticky undervoltage status bit |
| cp_en | output | 1 | Charge-pump enable |

## Verification
A deglitch count that is off by one changes the cycle in which `flt_status` rises, one edge early or late, after a high run of exactly DEG or DEG-1 samples. A fault register that holds or clears under the wrong policy appears at `flt_n` and `cp_en` on the first edge after `uv_below` falls. A sticky bit that clears too readily appears at `uv_sticky` on the first edge where a clear pulse meets a high flag. The bench compares every output to a cycle model on every cycle, so any such divergence is reported in the cycle it occurs.

// File: rtl/cp_uv_supervisor.sv
module cp_uv_supervisor #(
  parameter int DEG = 16,
  parameter int LVL_W = 2,
  parameter logic [LVL_W-1:0] HW_LVL = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_below,
  input  logic             mode_latch,
  input  logic [LVL_W-1:0] lvl_cfg,
  input  logic             clr_fault,
  input  logic             hw_strap,
  output logic [LVL_W-1:0] lvl_out,
  output logic             pulldown_en,
  output logic             flt_n,
  output logic             flt_status,
  output logic             uv_sticky,
  output logic             cp_en
);
  localparam int CW = (DEG > 2) ? $clog2(DEG) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEG - 1);

  logic [CW-1:0] cnt;
  logic          flt_q, uv_q;
  logic          latched, hit, clr_ok;

  assign latched = mode_latch & ~hw_strap;
  assign hit     = uv_below & (cnt == LAST);
  assign clr_ok  = clr_fault & ~uv_below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!uv_below)        cnt <= '0;
    else if (cnt != LAST)      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flt_q <= 1'b0;
    else if (hit)     flt_q <= 1'b1;
    else if (latched) flt_q <= flt_q & ~clr_ok;
    else              flt_q <= flt_q & uv_below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      uv_q <= 1'b0;
    else if (hit)    uv_q <= 1'b1;
    else if (clr_ok) uv_q <= 1'b0;
  end

  assign lvl_out     = hw_strap ? HW_LVL : lvl_cfg;
  assign pulldown_en = flt_q;
  assign flt_n       = ~flt_q;
  assign flt_status  = flt_q;
  assign uv_sticky   = uv_q;
  assign cp_en       = ~(flt_q & latched);
endmodule

module cp_uv_supervisor_chk #(
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uv_below,
  input logic             mode_latch,
  input logic             clr_fault,
  input logic             hw_strap,
  input logic             flt_status,
  input logic             uv_sticky,
  input logic             cp_en
);
  a_r1_rise_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_status) |-> $past(uv_below));
  a_r2_fault_implies_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flt_status |-> uv_sticky);
  a_r5_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_status && mode_latch && !hw_strap && !clr_fault) |=> flt_status);
  a_r5_cp_off_only_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_en |-> flt_status);
  a_r6_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_status && !uv_below && !(mode_latch && !hw_strap)) |=> !flt_status);
  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_sticky && !clr_fault) |=> uv_sticky);
  a_r9_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_below && uv_sticky) |=> uv_sticky);
endmodule

bind cp_uv_supervisor cp_uv_supervisor_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uv_below(uv_below), .mode_latch(mode_latch),
  .clr_fault(clr_fault), .hw_strap(hw_strap), .flt_status(flt_status),
  .uv_sticky(uv_sticky), .cp_en(cp_en)
);

// File: tb/sim_cp_uv_supervisor.sv
module sim_cp_uv_supervisor;
  localparam int D = 5;
  localparam int LW = 2;
  localparam logic [LW-1:0] HWL = 2'b01;

  logic clk = 0, rst_n = 0;
  logic uv_below = 0, mode_latch = 0, clr_fault = 0, hw_strap = 0;
  logic [LW-1:0] lvl_cfg = '0;
  logic [LW-1:0] lvl_out;
  logic pulldown_en, flt_n, flt_status, uv_sticky, cp_en;

  int total = 0, bad = 0;
  int m_cnt = 0;
  bit m_flt = 0, m_uv = 0;

  always #4 clk = ~clk;

  cp_uv_supervisor #(.DEG(D), .LVL_W(LW), .HW_LVL(HWL)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_below(uv_below), .mode_latch(mode_latch),
    .lvl_cfg(lvl_cfg), .clr_fault(clr_fault), .hw_strap(hw_strap),
    .lvl_out(lvl_out), .pulldown_en(pulldown_en), .flt_n(flt_n),
    .flt_status(flt_status), .uv_sticky(uv_sticky), .cp_en(cp_en));

  function automatic bit m_latched();
    return mode_latch && !hw_strap;
  endfunction

  function automatic int exp_lvl();
    return hw_strap ? int'(HWL) : int'(lvl_cfg);
  endfunction

  task automatic model_edge();
    bit hit, clr_ok;
    hit = uv_below && (m_cnt == D - 1);
    clr_ok = clr_fault && !uv_below;
    if (hit) m_flt = 1;
    else if (m_latched()) m_flt = m_flt && !clr_ok;
    else m_flt = m_flt && uv_below;
    if (hit) m_uv = 1;
    else if (clr_ok) m_uv = 0;
    if (!uv_below) m_cnt = 0;
    else if (m_cnt < D - 1) m_cnt++;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(flt_status, m_flt, "R2 flt_status vs model");
    chk(pulldown_en, m_flt, "R2 pulldown_en vs model");
    chk(flt_n, !m_flt, "R2 flt_n vs model");
    chk(uv_sticky, m_uv, "R7 uv_sticky vs model");
    chk(cp_en, !(m_flt && m_latched()), "R5 cp_en vs model");
    chk(lvl_out, exp_lvl(), hw_strap ? "R8 lvl_out" : "R3 lvl_out");
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic run(input bit f, input int n);
    uv_below = f;
    repeat (n) tick();
  endtask

  task automatic pulse_clr(input bit f);
    uv_below = f; clr_fault = 1; tick(); clr_fault = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flt_status, 0, "R10 reset flt_status");
    chk(cp_en, 1, "R10 reset cp_en");
    chk(flt_n, 1, "R10 reset flt_n");
    rst_n = 1;
    @(negedge clk);

    run(1, D - 1); run(0, 1);
    chk(flt_status, 0, "R1 short excursion");
    run(1, D - 1); run(0, 1); run(1, D - 1);
    chk(flt_status, 0, "R11 count restart");
    run(1, 1);
    chk(flt_status, 1, "R1 confirm at D-th sample");
    chk(flt_n, 0, "R2 pin asserted");
    chk(pulldown_en, 1, "R2 pulldowns");
    chk(cp_en, 1, "R6 cp stays on in auto");
    chk(mode_latch, 0, "R4 auto mode selected");
    run(0, 1);
    chk(flt_status, 0, "R6 auto clear");
    chk(uv_sticky, 1, "R7 sticky held");
    run(1, 1); pulse_clr(1);
    chk(uv_sticky, 1, "R9 clear ignored with flag high");
    pulse_clr(0);
    chk(uv_sticky, 0, "R7 clear releases sticky");

    mode_latch = 1;
    run(1, D);
    chk(flt_status, 1, "R4 latched fault");
    chk(cp_en, 0, "R5 cp off");
    run(0, 3);
    chk(flt_status, 1, "R5 fault held");
    chk(cp_en, 0, "R5 cp held off");
    run(1, 1); pulse_clr(1);
    chk(flt_status, 1, "R9 latched clear ignored");
    pulse_clr(0);
    chk(flt_status, 0, "R5 latched clear");
    chk(uv_sticky, 0, "R5 sticky cleared");
    chk(cp_en, 1, "R5 cp back on");

    lvl_cfg = 2'b11; run(0, 1);
    chk(lvl_out, 3, "R3 level passthrough");
    hw_strap = 1; run(0, 1);
    chk(lvl_out, int'(HWL), "R8 forced level");
    run(1, D); run(0, 1);
    chk(flt_status, 0, "R8 forced auto recovery");
    chk(uv_sticky, 1, "R8 sticky kept");
    pulse_clr(0);
    hw_strap = 0;

    void'($urandom(1234));
    for (int i = 0; i < 600; i++) begin
      int len;
      uv_below = ($urandom % 3) != 0;
      len = 1 + ($urandom % (2 * D));
      for (int k = 0; k < len; k++) begin
        clr_fault = ($urandom % 8) == 0;
        if (($urandom % 150) == 0) mode_latch = ~mode_latch;
        if (($urandom % 250) == 0) hw_strap = ~hw_strap;
        if (($urandom % 40) == 0) lvl_cfg = LW'($urandom);
        tick();
      end
    end
    clr_fault = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule